// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It writes a stream of 32-bit trace words into an internal RAM that wraps when it fills, so the most recent history is always kept. Software uses a small register port to set up a capture, start it, and stop it. Capture stops in one of three ways: software clears the enable bit, a manual flush is requested with stop-on-flush set, or a trigger pulse is seen while triggers are armed. A trigger does not stop capture at once. Capture goes on for a programmed number of further words and then stops by itself.

After capture has stopped, software drains the stored words by reading one data register again and again. The oldest word comes out first. Once every stored word has been returned, the data register reads all ones. The RAM depth is a power of two set by a parameter. Only the circular-buffer mode is implemented. The mode register stores its value but does not change behaviour.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the status register (0x00C) reads 0x4, the write-pointer register (0x018) reads 0, and the size register (0x004) reads the depth in words (2^ADDR_W).
- R2: While capturing (control register 0x020 bit 0 written to 1), every cycle with trace_valid high stores trace_data at the write pointer, and the pointer then advances by one.
- R3: When the write pointer wraps past the last entry, status bit 0 (full) is set and stays set until capture is started again. Writing carries on over the oldest data.
- R4: With trigger arming on (format register 0x304 bit 8), a trig_in pulse during capture lets exactly N more words be stored (N comes from the trigger-count register 0x01C, sampled at start). The word presented in the trigger cycle itself is stored as pre-trigger data. After the N words, capture stops, status bit 1 (triggered) reads 1, and later trace input is discarded.
- R5: With format bit 8 clear, trig_in has no effect: status bit 1 stays 0 and capture continues.
- R6: Writing format bit 6 requests a flush. Bit 6 reads 1 in the cycle after the write and 0 one cycle later. If format bit 12 was set before capture started, capture stops when the flush completes. Otherwise capture continues.
- R7: Reads of the data register (0x010) while stopped return the stored words oldest first. The first word comes from the write pointer if the buffer is full, otherwise from entry 0. Once all stored words are returned, each read gives 0xFFFFFFFF.
- R8: Writing 1 to control bit 0 while not capturing clears the write pointer, the full flag, the triggered flag and the readout position.
- R9: While capturing, writes to the trigger-count, mode and format registers are ignored, except for the format flush bit 6.
- R10: A data-register read while capturing returns 0xFFFFFFFF and does not advance the readout.
- R11: Writing 0 to control bit 0 ends capture. Status bit 2 (ready) is 1 whenever capture is not running and no flush is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_valid | input | 1 | Trace word present this cycle |
| trace_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances readout on the data register) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The assertions assume that reg_wr and reg_rd are never high together and that a restart is only requested while capture is idle, since only then are the start-clears-state and frozen-configuration properties meaningful. They also assume that trig_in and trace_valid are plain one-cycle strobes that need no handshake. The bench drives every register access and trace word as a single-cycle pulse set up on the falling edge, one operation per cycle. It programmes configuration only while the enable bit is clear, except in the scenarios that test that such writes are ignored.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    typedef enum logic [11:0] {
        A_SIZE = 12'h004,
        A_STAT = 12'h00C,
        A_RDAT = 12'h010,
        A_WPTR = 12'h018,
        A_TCNT = 12'h01C,
        A_CTRL = 12'h020,
        A_MODE = 12'h028,
        A_FMT  = 12'h304
    } reg_addr_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int FMT_FLUSH_BIT  = 6;
    localparam int FMT_TRIG_BIT   = 8;
    localparam int FMT_STOP_BIT   = 12;
    localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;

    typedef struct packed {
        logic trig_arm;
        logic stop_on_flush;
        logic [1:0] mode;
    } cfg_t;

    typedef struct packed {
        logic ready;
        logic trig;
        logic full;
    } stat_t;

    function automatic logic [31:0] pack_status(stat_t s);
        logic [31:0] r;
        r    = '0;
        r[0] = s.full;
        r[1] = s.trig;
        r[2] = s.ready;
        return r;
    endfunction

    function automatic logic [31:0] pack_fmt(cfg_t c, logic flushing);
        logic [31:0] r;
        r = '0;
        r[FMT_FLUSH_BIT] = flushing;
        r[FMT_TRIG_BIT]  = c.trig_arm;
        r[FMT_STOP_BIT]  = c.stop_on_flush;
        return r;
    endfunction

endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture #(
    parameter int AW = 4,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          en,
    input  logic          halt_req,
    input  logic          trace_valid,
    input  logic          trig_in,
    input  logic          trig_arm,
    input  logic [CW-1:0] tcnt_init,
    output logic          wr_en,
    output logic [AW-1:0] wptr,
    output logic          full,
    output logic          trig_seen,
    output logic          capturing,
    output logic          rem_zero
);
    logic          stopped;
    logic [CW-1:0] rem;
    logic          post_done;

    assign rem_zero  = (rem == '0);
    assign post_done = trig_seen & rem_zero;
    assign capturing = en & ~stopped;
    assign wr_en     = capturing & trace_valid & ~post_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr      <= '0;
            full      <= 1'b0;
            trig_seen <= 1'b0;
            stopped   <= 1'b0;
            rem       <= '0;
        end else if (start) begin
            wptr      <= '0;
            full      <= 1'b0;
            trig_seen <= 1'b0;
            stopped   <= 1'b0;
            rem       <= tcnt_init;
        end else begin
            if (wr_en) begin
                wptr <= wptr + 1'b1;
                if (&wptr) full <= 1'b1;
                if (trig_seen) rem <= rem - 1'b1;
            end
            if (capturing && trig_arm && trig_in && !trig_seen)
                trig_seen <= 1'b1;
            if (capturing && (post_done || halt_req))
                stopped <= 1'b1;
        end
    end
endmodule

// File: rtl/tcb_readout.sv
module tcb_readout #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          pop,
    input  logic          full,
    input  logic [AW-1:0] wptr,
    output logic [AW-1:0] raddr,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;

    logic [AW:0]   rcnt;
    logic [AW:0]   stored;
    logic [AW-1:0] base;

    assign stored = full ? (AW+1)'(DEPTH) : {1'b0, wptr};
    assign base   = full ? wptr : '0;
    assign empty  = (rcnt == stored);
    assign raddr  = base + rcnt[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || start) rcnt <= '0;
        else if (pop && !empty) rcnt <= rcnt + 1'b1;
    end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int TCNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trace_valid,
    input  logic [31:0] trace_data,
    input  logic        trig_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              en_q;
    logic [TCNT_W-1:0] tcnt_q;
    cfg_t              cfg_q;
    logic              flush_pend;

    logic              wr_en, full, trig_seen, capturing, rem_zero;
    logic [ADDR_W-1:0] wptr, raddr;
    logic [31:0]       ram_rdata;
    logic              rd_empty;

    logic ctrl_wr, fmt_wr, fmt_wr_flush, start, halt_req, rd_pop;

    assign ctrl_wr      = reg_wr && (reg_addr == A_CTRL);
    assign fmt_wr       = reg_wr && (reg_addr == A_FMT);
    assign fmt_wr_flush = fmt_wr && reg_wdata[FMT_FLUSH_BIT];
    assign start        = ctrl_wr && reg_wdata[CTRL_EN_BIT] && !capturing;
    assign halt_req     = flush_pend && cfg_q.stop_on_flush;
    assign rd_pop       = reg_rd && (reg_addr == A_RDAT) && !capturing;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            tcnt_q     <= '0;
            cfg_q      <= '0;
            flush_pend <= 1'b0;
        end else begin
            flush_pend <= fmt_wr_flush;
            if (ctrl_wr) en_q <= reg_wdata[CTRL_EN_BIT];
            if (reg_wr && !capturing) begin
                if (reg_addr == A_TCNT) tcnt_q <= reg_wdata[TCNT_W-1:0];
                if (reg_addr == A_MODE) cfg_q.mode <= reg_wdata[1:0];
                if (reg_addr == A_FMT) begin
                    cfg_q.trig_arm      <= reg_wdata[FMT_TRIG_BIT];
                    cfg_q.stop_on_flush <= reg_wdata[FMT_STOP_BIT];
                end
            end
        end
    end

    tcb_capture #(.AW(ADDR_W), .CW(TCNT_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .en         (en_q),
        .halt_req   (halt_req),
        .trace_valid(trace_valid),
        .trig_in    (trig_in),
        .trig_arm   (cfg_q.trig_arm),
        .tcnt_init  (tcnt_q),
        .wr_en      (wr_en),
        .wptr       (wptr),
        .full       (full),
        .trig_seen  (trig_seen),
        .capturing  (capturing),
        .rem_zero   (rem_zero)
    );

    tcb_ram #(.AW(ADDR_W), .DW(32)) u_ram (
        .clk  (clk),
        .we   (wr_en),
        .waddr(wptr),
        .wdata(trace_data),
        .raddr(raddr),
        .rdata(ram_rdata)
    );

    tcb_readout #(.AW(ADDR_W)) u_rdo (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .pop  (rd_pop),
        .full (full),
        .wptr (wptr),
        .raddr(raddr),
        .empty(rd_empty)
    );

    stat_t st;
    always_comb begin
        st.full   = full;
        st.trig   = trig_seen;
        st.ready  = ~capturing & ~flush_pend;
        reg_rdata = '0;
        case (reg_addr)
            A_SIZE: reg_rdata = 32'(DEPTH);
            A_STAT: reg_rdata = pack_status(st);
            A_RDAT: reg_rdata = (capturing || rd_empty) ? EMPTY_WORD : ram_rdata;
            A_WPTR: reg_rdata = 32'(wptr);
            A_TCNT: reg_rdata = 32'(tcnt_q);
            A_CTRL: reg_rdata = {31'b0, en_q};
            A_MODE: reg_rdata = 32'(cfg_q.mode);
            A_FMT:  reg_rdata = pack_fmt(cfg_q, flush_pend);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker
    import tcb_pkg::*;
#(
    parameter int TCNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              capturing,
    input logic              wr_en,
    input logic              full,
    input logic              trig_seen,
    input logic              rem_zero,
    input logic              start,
    input logic              flush_pend,
    input logic              fmt_wr_flush,
    input logic [TCNT_W-1:0] tcnt_q,
    input logic              reg_rd,
    input logic [11:0]       reg_addr,
    input logic [31:0]       reg_rdata
);
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (full && !start) |=> full);                                          // R3
    AST_NO_STORE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !capturing |-> !wr_en);                                              // R4
    AST_TRIG_STOP: assert property (@(posedge clk) disable iff (rst)
        (capturing && trig_seen && rem_zero) |=> !capturing);                // R4
    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flush_pend && !fmt_wr_flush) |=> !flush_pend);                      // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (!full && !trig_seen));                                    // R8
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        capturing |=> $stable(tcnt_q));                                      // R9
    AST_BUSY_SENTINEL: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_RDAT && capturing) |-> reg_rdata == EMPTY_WORD); // R10
endmodule

bind trace_capture_buf tcb_checker #(.TCNT_W(TCNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .capturing   (capturing),
    .wr_en       (wr_en),
    .full        (full),
    .trig_seen   (trig_seen),
    .rem_zero    (rem_zero),
    .start       (start),
    .flush_pend  (flush_pend),
    .fmt_wr_flush(fmt_wr_flush),
    .tcnt_q      (tcnt_q),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata)
);

// File: tb/trace_capture_buf_tb.sv
module trace_capture_buf_tb;
    import tcb_pkg::*;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_valid = 1'b0;
    logic [31:0] trace_data = '0;
    logic        trig_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    trace_capture_buf #(.ADDR_W(AW), .TCNT_W(16)) u_dut (
        .clk(clk), .rst(rst), .trace_valid(trace_valid), .trace_data(trace_data),
        .trig_in(trig_in), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Each task starts just after a falling edge and ends on one.
    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push(logic [31:0] d, logic trg);
        trace_valid = 1'b1; trace_data = d; trig_in = trg;
        @(negedge clk);
        trace_valid = 1'b0; trig_in = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_STAT, v); check("R1 status", v, 32'h4);
        rd(A_WPTR, v); check("R1 wptr", v, 0);
        rd(A_SIZE, v); check("R1 size", v, DEPTH);
    endtask

    task automatic t_basic;
        logic [31:0] v;
        wr(A_FMT, 0);
        wr(A_CTRL, 1);
        for (int i = 0; i < 5; i++) push(32'h100 + i, 1'b0);
        rd(A_STAT, v); check("R11 running not ready", v, 32'h0);
        rd(A_WPTR, v); check("R2 wptr", v, 5);
        rd(A_RDAT, v); check("R10 busy read", v, EMPTY_WORD);
        wr(A_CTRL, 0);
        rd(A_STAT, v); check("R11 stopped ready", v, 32'h4);
        for (int i = 0; i < 5; i++) begin
            rd(A_RDAT, v); check("R7 order linear", v, 32'h100 + i);
        end
        rd(A_RDAT, v); check("R7 sentinel", v, EMPTY_WORD);
        rd(A_RDAT, v); check("R7 sentinel again", v, EMPTY_WORD);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(A_CTRL, 1);
        for (int i = 0; i < DEPTH + 4; i++) push(32'h300 + i, 1'b0);
        wr(A_CTRL, 0);
        rd(A_STAT, v); check("R3 full", v, 32'h5);
        rd(A_WPTR, v); check("R3 wptr wrapped", v, 4);
        for (int k = 0; k < DEPTH; k++) begin
            rd(A_RDAT, v); check("R7 order wrapped", v, 32'h300 + 4 + k);
        end
        rd(A_RDAT, v); check("R7 sentinel wrapped", v, EMPTY_WORD);
    endtask

    task automatic t_unarmed;
        logic [31:0] v;
        wr(A_FMT, 0);
        wr(A_CTRL, 1);
        push(32'h500, 1'b1);
        for (int i = 1; i < 5; i++) push(32'h500 + i, 1'b0);
        rd(A_STAT, v); check("R5 no trigger", v, 32'h0);
        rd(A_WPTR, v); check("R5 all stored", v, 5);
        wr(A_CTRL, 0);
    endtask

    task automatic t_flush;
        logic [31:0] v;
        wr(A_CTRL, 1);
        push(32'h600, 1'b0); push(32'h601, 1'b0);
        wr(A_FMT, 32'h40);
        rd(A_FMT, v); check("R6 flush busy", v, 32'h40);
        rd(A_FMT, v); check("R6 flush done", v, 32'h0);
        rd(A_STAT, v); check("R6 no stop", v, 32'h0);
        push(32'h602, 1'b0);
        rd(A_WPTR, v); check("R6 still capturing", v, 3);
        wr(A_CTRL, 0);
        wr(A_FMT, 32'h1000);
        wr(A_CTRL, 1);
        push(32'h610, 1'b0); push(32'h611, 1'b0);
        wr(A_FMT, 32'h1040);
        rd(A_FMT, v); check("R6 flush busy stop", v, 32'h1040);
        rd(A_STAT, v); check("R6 stopped by flush", v, 32'h4);
        push(32'h612, 1'b0);
        rd(A_WPTR, v); check("R6 input discarded", v, 2);
        wr(A_CTRL, 0);
        wr(A_FMT, 0);
    endtask

    task automatic t_cfg_hold;
        logic [31:0] v;
        wr(A_TCNT, 5);
        wr(A_CTRL, 1);
        wr(A_TCNT, 9);
        wr(A_FMT, 32'h100);
        wr(A_CTRL, 0);
        rd(A_TCNT, v); check("R9 tcnt kept", v, 5);
        rd(A_FMT, v); check("R9 fmt kept", v, 0);
    endtask

    task automatic t_trigger;
        logic [31:0] v;
        wr(A_FMT, 32'h100);
        wr(A_TCNT, 3);
        wr(A_CTRL, 1);
        push(32'h400, 1'b0); push(32'h401, 1'b0);
        push(32'h402, 1'b1);
        for (int i = 3; i < 8; i++) push(32'h400 + i, 1'b0);
        rd(A_STAT, v); check("R4 triggered stop", v, 32'h6);
        rd(A_WPTR, v); check("R4 word count", v, 6);
        for (int i = 0; i < 6; i++) begin
            rd(A_RDAT, v); check("R4 stored words", v, 32'h400 + i);
        end
        rd(A_RDAT, v); check("R4 no extra word", v, EMPTY_WORD);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        wr(A_CTRL, 1);
        rd(A_STAT, v); check("R8 flags cleared", v, 32'h0);
        rd(A_WPTR, v); check("R8 wptr cleared", v, 0);
        wr(A_CTRL, 0);
        rd(A_RDAT, v); check("R8 readout cleared", v, EMPTY_WORD);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_wrap();
        t_unarmed();
        t_flush();
        t_cfg_hold();
        t_trigger();
        t_restart();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule